// File: doc/BRIEF.md
# I2C Target Controller with Register-Driven Host Port

This block attaches a two-wire serial bus to a small register file. A single mode bit chooses between two personalities. In target mode, hardware watches the bus, recognises start, repeated-start and stop conditions, compares the seven address bits against a programmable own address, acknowledges, and moves data bytes between the bus and a one-byte data register. Each event that needs software attention raises a level interrupt. A two-bit cause field in the control register says which event it was. Reception of the all-zero address sets a sticky general-call flag.

In host mode the hardware sequencer is parked. Software then drives the bus one wire level at a time through a bit-bang register. That register has a data level, a data drive enable and a clock level. A sampled data-input bit captures SDA on each rising SCL edge while the data drive is off. Both wires are open-drain: the pin outputs are pull-low enables, and the incoming levels pass through a synchronizer before any logic looks at them.

Top module: `i2c_dual_mode`

## Requirements
- R1: After reset, every register reads 0x00, the block is in target mode, `irq` is 0, and neither `scl_oe` nor `sda_oe` is asserted.
- R2: In host mode (control bit 0 = 1), `sda_oe` is 1 exactly when bit-bang bit 1 (drive enable) is 1 and bit-bang bit 0 (data level) is 0. With bit 1 at 0, SDA is released.
- R3: In host mode, `scl_oe` is the inverse of bit-bang bit 2 (clock level). In target mode, `scl_oe` is never asserted.
- R4: In host mode with bit-bang bit 1 at 0, bit-bang bit 3 (read-only) takes the SDA level on each rising SCL edge and holds it otherwise. While bit 1 is 1, bit 3 does not change.
- R5: In target mode, the block pulls SDA low during the ninth clock after a start only when the seven address bits equal the own-address register (offset 1, bits 6:0) or are all zero. For any other address it stays silent and raises no interrupt.
- R6: An address match raises `irq` with cause 00 (control bits 4:3) when the preceding start came from an idle bus, and 01 when it was a repeated start.
- R7: In a write transfer (R/W bit 0), each received byte is acknowledged. It is placed in the data register (offset 2) and raises cause 10 once the acknowledge clock ends.
- R8: In a read transfer (R/W bit 1), the data register is sent MSB first, reloaded after each byte the host acknowledges. Each byte raises cause 10 after its acknowledge clock.
- R9: A stop after a matched address raises cause 11 only if control bit 1 (stop interrupt enable) is 1.
- R10: Receiving the all-zero address sets control bit 2. A control write with bit 2 at 0 clears it, and a write with bit 2 at 1 never sets it.
- R11: `irq` (also visible as control bit 7) stays at 1 until software writes the control register (offset 0), which clears it. The cause stays readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register offset: 0 control, 1 own address, 2 data, 3 bit-bang |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected offset |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | Level interrupt request |

## Verification
The properties assume that the wire levels reaching `scl_i` and `sda_i` come from an open-drain bus with the block's own pull enables folded in. They also assume that software writes one register per strobe. The bench therefore models each wire as released-high unless the bench host or the block pulls it. Every wire level is held for ten clocks, far longer than the synchronizer and edge-detect delay, so no condition is seen twice or missed. SDA changes only while SCL is low, except inside deliberate start and stop sequences. Interrupts are acknowledged only after the cause has been sampled.

// File: rtl/i2c_dm_pkg.sv
package i2c_dm_pkg;

  localparam int BYTE_W  = 8;
  localparam int ADR_W   = 7;
  localparam int REG_AW  = 2;
  localparam int CNT_W   = 4;

  localparam logic [REG_AW-1:0] RA_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] RA_OWN  = 2'd1;
  localparam logic [REG_AW-1:0] RA_DATA = 2'd2;
  localparam logic [REG_AW-1:0] RA_BB   = 2'd3;

  // control register bit positions
  localparam int CB_MODE = 0;
  localparam int CB_STIE = 1;
  localparam int CB_GC   = 2;

  // bit-bang register bit positions
  localparam int BB_DOUT = 0;
  localparam int BB_DOE  = 1;
  localparam int BB_COUT = 2;
  localparam int BB_DIN  = 3;

  typedef enum logic [1:0] {
    CAUSE_START  = 2'b00,
    CAUSE_RSTART = 2'b01,
    CAUSE_DATA   = 2'b10,
    CAUSE_STOP   = 2'b11
  } cause_e;

  typedef enum logic [2:0] {
    TS_IDLE,
    TS_ADDR,
    TS_AACK,
    TS_RX,
    TS_RACK,
    TS_TX,
    TS_TACK,
    TS_WAIT
  } tstate_e;

endpackage

// File: rtl/i2c_dm_sync.sv
module i2c_dm_sync #(
  parameter int              STAGES  = 2,
  parameter int              W       = 2,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/i2c_dm_busmon.sv
module i2c_dm_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    scl_rise = scl_s & ~scl_q;
    scl_fall = ~scl_s & scl_q;
    // data edges only count as conditions while the clock stays high
    start_c  = scl_s & scl_q & sda_q & ~sda_s;
    stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  end

endmodule

// File: rtl/i2c_dm_bitbang.sv
module i2c_dm_bitbang (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode,
  input  logic       wr_en,
  input  logic [2:0] wdata,
  input  logic       scl_rise,
  input  logic       sda_s,
  output logic       dout_q,
  output logic       doe_q,
  output logic       cout_q,
  output logic       din_q,
  output logic       sda_low,
  output logic       scl_low
);

  logic dout_d, doe_d, cout_d, din_d;

  always_comb begin
    dout_d = dout_q;
    doe_d  = doe_q;
    cout_d = cout_q;
    din_d  = din_q;
    if (wr_en) begin
      dout_d = wdata[0];
      doe_d  = wdata[1];
      cout_d = wdata[2];
    end
    if (mode && !doe_q && scl_rise) din_d = sda_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= 1'b0;
      doe_q  <= 1'b0;
      cout_q <= 1'b0;
      din_q  <= 1'b0;
    end else begin
      dout_q <= dout_d;
      doe_q  <= doe_d;
      cout_q <= cout_d;
      din_q  <= din_d;
    end
  end

  assign sda_low = doe_q & ~dout_q;
  assign scl_low = ~cout_q;

endmodule

// File: rtl/i2c_dm_target.sv
module i2c_dm_target
  import i2c_dm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_c,
  input  logic              stop_c,
  input  logic              stop_ie,
  input  logic [ADR_W-1:0]  own_addr,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              sda_low,
  output logic              ev_valid,
  output logic [1:0]        ev_cause,
  output logic              gc_set,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_byte
);

  tstate_e           st_q, st_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              rw_q, rw_d;
  logic              busy_q, busy_d;
  logic              match_q, match_d;
  logic              rep_q, rep_d;
  logic              gch_q, gch_d;
  logic              nack_q, nack_d;
  logic              drv_q, drv_d;

  logic [ADR_W-1:0]  rx_adr;
  logic              adr_zero, adr_hit;

  assign rx_adr   = sh_q[BYTE_W-1:1];
  assign adr_zero = (rx_adr == '0);
  assign adr_hit  = (rx_adr == own_addr) | adr_zero;

  always_comb begin
    st_d     = st_q;
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    rw_d     = rw_q;
    busy_d   = busy_q;
    match_d  = match_q;
    rep_d    = rep_q;
    gch_d    = gch_q;
    nack_d   = nack_q;
    drv_d    = drv_q;
    ev_valid = 1'b0;
    ev_cause = CAUSE_START;
    gc_set   = 1'b0;
    rx_valid = 1'b0;

    if (!en) begin
      st_d    = TS_IDLE;
      busy_d  = 1'b0;
      match_d = 1'b0;
      drv_d   = 1'b0;
      cnt_d   = '0;
    end else if (start_c) begin
      st_d    = TS_ADDR;
      sh_d    = '0;
      cnt_d   = '0;
      rep_d   = busy_q;
      busy_d  = 1'b1;
      match_d = 1'b0;
      drv_d   = 1'b0;
    end else if (stop_c) begin
      st_d    = TS_IDLE;
      busy_d  = 1'b0;
      drv_d   = 1'b0;
      match_d = 1'b0;
      if (match_q && stop_ie) begin
        ev_valid = 1'b1;
        ev_cause = CAUSE_STOP;
      end
    end else begin
      unique case (st_q)
        TS_ADDR: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
            cnt_d = '0;
            if (adr_hit) begin
              drv_d = 1'b1;
              st_d  = TS_AACK;
              rw_d  = sh_q[0] & ~adr_zero;
              gch_d = adr_zero;
            end else begin
              st_d  = TS_WAIT;
            end
          end
        end
        TS_AACK: begin
          if (scl_fall) begin
            match_d  = 1'b1;
            ev_valid = 1'b1;
            ev_cause = rep_q ? CAUSE_RSTART : CAUSE_START;
            gc_set   = gch_q;
            cnt_d    = '0;
            if (rw_q) begin
              sh_d  = tx_byte;
              drv_d = ~tx_byte[BYTE_W-1];
              st_d  = TS_TX;
            end else begin
              drv_d = 1'b0;
              st_d  = TS_RX;
            end
          end
        end
        TS_RX: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
            drv_d = 1'b1;
            cnt_d = '0;
            st_d  = TS_RACK;
          end
        end
        TS_RACK: begin
          if (scl_fall) begin
            drv_d    = 1'b0;
            ev_valid = 1'b1;
            ev_cause = CAUSE_DATA;
            rx_valid = 1'b1;
            st_d     = TS_RX;
          end
        end
        TS_TX: begin
          if (scl_fall) begin
            if (cnt_q == CNT_W'(BYTE_W - 1)) begin
              drv_d = 1'b0;
              cnt_d = '0;
              st_d  = TS_TACK;
            end else begin
              sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
              drv_d = ~sh_q[BYTE_W-2];
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        TS_TACK: begin
          if (scl_rise) begin
            nack_d = sda_s;
          end else if (scl_fall) begin
            ev_valid = 1'b1;
            ev_cause = CAUSE_DATA;
            if (!nack_q) begin
              sh_d  = tx_byte;
              drv_d = ~tx_byte[BYTE_W-1];
              st_d  = TS_TX;
            end else begin
              drv_d = 1'b0;
              st_d  = TS_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= TS_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      rw_q    <= 1'b0;
      busy_q  <= 1'b0;
      match_q <= 1'b0;
      rep_q   <= 1'b0;
      gch_q   <= 1'b0;
      nack_q  <= 1'b0;
      drv_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      rw_q    <= rw_d;
      busy_q  <= busy_d;
      match_q <= match_d;
      rep_q   <= rep_d;
      gch_q   <= gch_d;
      nack_q  <= nack_d;
      drv_q   <= drv_d;
    end
  end

  assign sda_low = drv_q;
  assign rx_byte = sh_q;

endmodule

// File: rtl/i2c_dual_mode.sv
module i2c_dual_mode
  import i2c_dm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              irq
);

  logic rst_sync, rst_ni;

  i2c_dm_sync #(.STAGES(2), .W(1), .RST_VAL(1'b0)) u_rsync (
    .clk(clk), .rst_n(rst_n), .din(1'b1), .dout(rst_sync)
  );
  assign rst_ni = rst_sync;

  // wire synchronizer and condition detection
  logic [1:0] line_s;
  logic       scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;

  i2c_dm_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(2'b11)) u_lsync (
    .clk(clk), .rst_n(rst_ni), .din({scl_i, sda_i}), .dout(line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  i2c_dm_busmon u_mon (
    .clk(clk), .rst_n(rst_ni), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c)
  );

  // register state
  logic              mode_q, mode_d;
  logic              stie_q, stie_d;
  logic              gc_q, gc_d;
  logic [1:0]        cause_q, cause_d;
  logic              irq_q, irq_d;
  logic [ADR_W-1:0]  own_q, own_d;
  logic [BYTE_W-1:0] data_q, data_d;

  logic wr_ctrl, wr_own, wr_data, wr_bb;
  assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
  assign wr_own  = reg_wr && (reg_addr == RA_OWN);
  assign wr_data = reg_wr && (reg_addr == RA_DATA);
  assign wr_bb   = reg_wr && (reg_addr == RA_BB);

  // target sequencer
  logic              t_sda_low, ev_valid, gc_set, rx_valid;
  logic [1:0]        ev_cause;
  logic [BYTE_W-1:0] rx_byte;

  i2c_dm_target u_tgt (
    .clk(clk), .rst_n(rst_ni), .en(~mode_q), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c),
    .stop_ie(stie_q), .own_addr(own_q), .tx_byte(data_q),
    .sda_low(t_sda_low), .ev_valid(ev_valid), .ev_cause(ev_cause),
    .gc_set(gc_set), .rx_valid(rx_valid), .rx_byte(rx_byte)
  );

  // software-driven host port
  logic bb_dout, bb_oe, bb_cout, bb_din, h_sda_low, h_scl_low;

  i2c_dm_bitbang u_bb (
    .clk(clk), .rst_n(rst_ni), .mode(mode_q), .wr_en(wr_bb),
    .wdata(reg_wdata[2:0]), .scl_rise(scl_rise), .sda_s(sda_s),
    .dout_q(bb_dout), .doe_q(bb_oe), .cout_q(bb_cout), .din_q(bb_din),
    .sda_low(h_sda_low), .scl_low(h_scl_low)
  );

  always_comb begin
    mode_d  = mode_q;
    stie_d  = stie_q;
    gc_d    = gc_q;
    cause_d = cause_q;
    irq_d   = irq_q;
    own_d   = own_q;
    data_d  = data_q;
    if (wr_ctrl) begin
      mode_d = reg_wdata[CB_MODE];
      stie_d = reg_wdata[CB_STIE];
      gc_d   = gc_q & reg_wdata[CB_GC];
      irq_d  = 1'b0;
    end
    if (wr_own)  own_d  = reg_wdata[ADR_W-1:0];
    if (wr_data) data_d = reg_wdata;
    // hardware events take precedence over a same-cycle software write
    if (gc_set)   gc_d   = 1'b1;
    if (rx_valid) data_d = rx_byte;
    if (ev_valid) begin
      irq_d   = 1'b1;
      cause_d = ev_cause;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= 1'b0;
      stie_q  <= 1'b0;
      gc_q    <= 1'b0;
      cause_q <= 2'b00;
      irq_q   <= 1'b0;
      own_q   <= '0;
      data_q  <= '0;
    end else begin
      mode_q  <= mode_d;
      stie_q  <= stie_d;
      gc_q    <= gc_d;
      cause_q <= cause_d;
      irq_q   <= irq_d;
      own_q   <= own_d;
      data_q  <= data_d;
    end
  end

  always_comb begin
    unique case (reg_addr)
      RA_CTRL: reg_rdata = {irq_q, 2'b00, cause_q, gc_q, stie_q, mode_q};
      RA_OWN:  reg_rdata = {1'b0, own_q};
      RA_DATA: reg_rdata = data_q;
      default: reg_rdata = {4'h0, bb_din, bb_cout, bb_oe, bb_dout};
    endcase
  end

  assign sda_oe = mode_q ? h_sda_low : t_sda_low;
  assign scl_oe = mode_q & h_scl_low;
  assign irq    = irq_q;

endmodule

// File: rtl/i2c_dual_mode_chk.sv
module i2c_dual_mode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] reg_addr,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       mode_q,
  input logic       stie_q,
  input logic       gc_q,
  input logic       irq_q,
  input logic [1:0] cause_q,
  input logic       bb_oe,
  input logic       bb_din
);

  a_r3_no_scl_in_target: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> !scl_oe);

  a_r2_sda_released: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !bb_oe) |-> !sda_oe);

  a_r4_din_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && bb_oe) |=> $stable(bb_din));

  a_r11_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !(reg_wr && reg_addr == 2'd0)) |=> irq_q);

  a_r10_gc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (gc_q && !(reg_wr && reg_addr == 2'd0 && !reg_wdata[2])) |=> gc_q);

  a_r9_stop_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_q) && cause_q == 2'b11) |-> $past(stie_q));

endmodule

bind i2c_dual_mode i2c_dual_mode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .mode_q(mode_q), .stie_q(stie_q), .gc_q(gc_q), .irq_q(irq_q),
  .cause_q(cause_q), .bb_oe(bb_oe), .bb_din(bb_din)
);

// File: tb/test_i2c_dual_mode.sv
module test_i2c_dual_mode;

  localparam int H = 10;

  logic       clk;
  logic       rst_n;
  logic [1:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       scl_oe, sda_oe, irq;
  logic       tb_scl_low, tb_sda_low;
  logic       scl_line, sda_line;

  int total;
  int bad;
  logic [1:0] exp_cause[$];
  string      exp_tag[$];
  logic [7:0] shadow;

  assign scl_line = ~(tb_scl_low | scl_oe);
  assign sda_line = ~(tb_sda_low | sda_oe);

  i2c_dual_mode i_i2c_dual_mode (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_i(scl_line),
    .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 2'd0;
  endtask

  task automatic expect_irq(input logic [1:0] c, input string tag);
    exp_cause.push_back(c);
    exp_tag.push_back(tag);
  endtask

  // monitor: compares each raised cause with the scoreboard
  initial begin
    forever begin
      @(posedge irq);
      #1;
      if (exp_cause.size() == 0) begin
        total++; bad++;
        $display("FAIL R11 unexpected interrupt actual=%0h expected=none", reg_rdata[4:3]);
      end else begin
        logic [1:0] c;
        string t;
        c = exp_cause.pop_front();
        t = exp_tag.pop_front();
        chk(t, reg_rdata[4:3], c);
      end
    end
  end

  task automatic bit_io(input logic b, output logic s);
    tb_sda_low = ~b;
    ticks(H);
    tb_scl_low = 1'b0;
    ticks(H/2);
    s = sda_line;
    ticks(H/2);
    tb_scl_low = 1'b1;
    ticks(H);
  endtask

  task automatic bus_start();
    tb_sda_low = 1'b0; ticks(H);
    tb_scl_low = 1'b0; ticks(H);
    tb_sda_low = 1'b1; ticks(H);
    tb_scl_low = 1'b1; ticks(H);
  endtask

  task automatic bus_stop();
    tb_sda_low = 1'b1; ticks(H);
    tb_scl_low = 1'b0; ticks(H);
    tb_sda_low = 1'b0; ticks(H);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(d[i], s);
    bit_io(1'b1, ack);
  endtask

  task automatic rbyte(input logic host_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s);
      d[i] = s;
    end
    bit_io(~host_ack, s);
  endtask

  task automatic ack_irq(input string tag);
    chk({tag, " irq held"}, irq, 1);
    ticks(20);
    chk("R11 irq still held before write", irq, 1);
    wr(2'd0, shadow);
    ticks(2);
    chk("R11 irq cleared by control write", irq, 0);
  endtask

  initial begin
    logic [7:0] d;
    logic       a;
    total = 0; bad = 0;
    rst_n = 1'b0;
    reg_addr = 2'd0; reg_wr = 1'b0; reg_wdata = 8'h00;
    tb_scl_low = 1'b0; tb_sda_low = 1'b0;
    ticks(5);
    rst_n = 1'b1;
    ticks(5);

    // R1 reset state
    rd(2'd0, d); chk("R1 control reset", d, 8'h00);
    rd(2'd1, d); chk("R1 own address reset", d, 8'h00);
    rd(2'd2, d); chk("R1 data reset", d, 8'h00);
    rd(2'd3, d); chk("R1 bit-bang reset", d, 8'h00);
    chk("R1 irq low", irq, 0);
    chk("R1 scl released", scl_oe, 0);
    chk("R1 sda released", sda_oe, 0);

    wr(2'd1, 8'h2A);
    shadow = 8'h06;             // stop irq enabled, gc bit written as 1
    wr(2'd0, shadow);
    rd(2'd0, d); chk("R10 writing 1 does not set general call", d[2], 0);

    // write transfer with data bytes and a repeated start
    expect_irq(2'b00, "R6 start+match cause");
    bus_start();
    wbyte(8'h54, a); chk("R5 address acked", a, 0);
    ack_irq("R6");
    expect_irq(2'b10, "R7 data cause");
    wbyte(8'h9C, a); chk("R7 byte acked", a, 0);
    rd(2'd2, d); chk("R7 data register", d, 8'h9C);
    ack_irq("R7");
    expect_irq(2'b10, "R7 data cause");
    wbyte(8'h31, a); chk("R7 byte acked", a, 0);
    rd(2'd2, d); chk("R7 data register", d, 8'h31);
    ack_irq("R7");
    expect_irq(2'b01, "R6 repeated start cause");
    bus_start();
    wbyte(8'h54, a); chk("R5 address acked after repeat", a, 0);
    ack_irq("R6");
    expect_irq(2'b10, "R7 data cause");
    wbyte(8'h77, a);
    rd(2'd2, d); chk("R7 data register", d, 8'h77);
    ack_irq("R7");
    expect_irq(2'b11, "R9 stop cause");
    bus_stop();
    ack_irq("R9");

    // foreign address
    bus_start();
    wbyte(8'h56, a); chk("R5 foreign address not acked", a, 1);
    chk("R5 no irq for foreign address", irq, 0);
    bus_stop();
    ticks(10);
    chk("R9 no stop irq without match", irq, 0);

    // read transfer
    wr(2'd2, 8'h3C);
    expect_irq(2'b00, "R6 start+match cause");
    bus_start();
    wbyte(8'h55, a); chk("R5 read address acked", a, 0);
    ack_irq("R6");
    wr(2'd2, 8'hC3);
    expect_irq(2'b10, "R8 data cause");
    rbyte(1'b1, d); chk("R8 first byte msb first", d, 8'h3C);
    ack_irq("R8");
    expect_irq(2'b10, "R8 data cause");
    rbyte(1'b0, d); chk("R8 reloaded byte", d, 8'hC3);
    ack_irq("R8");
    expect_irq(2'b11, "R9 stop cause");
    bus_stop();
    ack_irq("R9");

    // stop interrupt disabled
    shadow = 8'h04;
    wr(2'd0, shadow);
    expect_irq(2'b00, "R6 start+match cause");
    bus_start();
    wbyte(8'h54, a);
    ack_irq("R6");
    bus_stop();
    ticks(10);
    chk("R9 stop irq suppressed", irq, 0);

    // general call
    expect_irq(2'b00, "R10 general call cause");
    bus_start();
    wbyte(8'h00, a); chk("R10 general call acked", a, 0);
    rd(2'd0, d); chk("R10 general call flag set", d[2], 1);
    ack_irq("R10");
    rd(2'd0, d); chk("R10 flag kept by write of 1", d[2], 1);
    bus_stop();
    shadow = 8'h00;
    wr(2'd0, shadow);
    rd(2'd0, d); chk("R10 flag cleared by write of 0", d[2], 0);

    // host mode bit-bang
    tb_scl_low = 1'b0; tb_sda_low = 1'b0;
    shadow = 8'h01;
    wr(2'd0, shadow);
    wr(2'd3, 8'h06); ticks(1);
    chk("R2 sda pulled with enable and level 0", sda_oe, 1);
    chk("R3 scl released with level 1", scl_oe, 0);
    wr(2'd3, 8'h07); ticks(1);
    chk("R2 sda released with level 1", sda_oe, 0);
    wr(2'd3, 8'h01); ticks(1);
    chk("R2 sda released with enable 0", sda_oe, 0);
    chk("R3 scl pulled with level 0", scl_oe, 1);
    tb_sda_low = 1'b1;
    ticks(4);
    wr(2'd3, 8'h04); ticks(6);
    rd(2'd3, d); chk("R4 low sampled on clock rise", d[3], 0);
    tb_sda_low = 1'b0; ticks(6);
    rd(2'd3, d); chk("R4 held without clock edge", d[3], 0);
    wr(2'd3, 8'h00); ticks(6);
    wr(2'd3, 8'h04); ticks(6);
    rd(2'd3, d); chk("R4 high sampled on clock rise", d[3], 1);
    wr(2'd3, 8'h03); ticks(2);
    tb_sda_low = 1'b1; ticks(4);
    wr(2'd3, 8'h07); ticks(6);
    rd(2'd3, d); chk("R4 no capture while driving", d[3], 1);
    tb_sda_low = 1'b0;

    ticks(10);
    chk("R11 no pending expected interrupts", exp_cause.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule